// File: doc/BRIEF.md
# Two-Dimensional Scan Address Generator

This block walks a two-dimensional index space the way a pair of nested loops would, and hands out one (row, column) pair per accepted beat. Seven parameters describe the walk. Each of the two dimensions has a first index, an increment and a ceiling. A single nesting selector picks which dimension is swept in the inner loop. Software writes these parameters through a small write-only register port while the block is idle, then pulses `start`.

Addresses leave on a valid/ready stream. Each beat carries a flag that marks the end of an inner sweep, and a second flag that marks the final pair of the whole walk. One cycle after that final pair is taken, a done pulse appears and the block is idle again. A zero increment, or a first index above its ceiling, is refused with an error flag instead of a walk.

The block has no shared or global state, so several copies can each scan a different array at the same time. Turning the pair into a linear memory address is left to the consumer.

Top module: `scan_agen`

## Requirements
- R1: After synchronous reset `out_valid`, `scan_done`, `busy`, `cfg_err`, `out_last_inner` and `out_last_scan` are all 0.
- R2: A write (`cfg_we`=1) stores `cfg_wdata` into the parameter picked by `cfg_sel`: 0 row first index, 1 row increment, 2 row ceiling, 3 column first index, 4 column increment, 5 column ceiling, 6 nesting selector (any nonzero data sets it, zero clears it). A written parameter is used from the next accepted start onward.
- R3: When the nesting selector is set, the column index is swept in the inner loop and the row index advances in the outer loop (video-scan order).
- R4: When the nesting selector is clear, the row index is swept in the inner loop and the column index advances in the outer loop.
- R5: The inner index starts at its first index and grows by its increment on each accepted beat. When the next value would exceed the ceiling, the inner index reloads its first index and the outer index grows by its own increment. No index above its ceiling is ever emitted, even when the ceiling is not a whole number of increments away or when the sum passes 65535 (indices are unsigned 16 bits). The number of beats is the product of the two per-dimension counts.
- R6: `out_last_inner` is 1 on exactly those beats whose inner index is the last one of its sweep. `out_last_scan` is 1 only on the final beat of the walk.
- R7: In the cycle after the final beat is accepted, `scan_done` is 1 for exactly one cycle while `out_valid` and `busy` are 0. The first pair appears in the cycle after an accepted start, and `out_valid` stays 1 from then until the final beat is taken.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_row` and `out_col` hold their values.
- R9: A start with either increment equal to zero, or with a first index above its ceiling, sets `cfg_err` and emits no pair. `busy` stays 0. A later accepted start clears `cfg_err`.
- R10: Parameter writes made while `busy` is 1 are ignored.
- R11: A `start` pulse while `busy` is 1 is ignored and does not disturb the running walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_sel | input | 3 | Parameter select |
| cfg_wdata | input | IDX_W | Parameter write data |
| start | input | 1 | Start pulse |
| out_valid | output | 1 | Address pair valid |
| out_ready | input | 1 | Consumer accepts the pair |
| out_row | output | IDX_W | Row index |
| out_col | output | IDX_W | Column index |
| out_last_inner | output | 1 | Pair ends an inner sweep |
| out_last_scan | output | 1 | Pair is the final one of the walk |
| scan_done | output | 1 | One-cycle pulse after the final pair |
| busy | output | 1 | Walk in progress |
| cfg_err | output | 1 | Last start refused as misconfigured |

## Verification
The bench builds the block with its default 16-bit index width. At that width a row walk starting at 65530 with increment 4 pushes the sum past 65535, which exercises the carry-aware ceiling test. A table of parameter sets covers both nesting orders, ceilings that are not a whole number of increments away, single-point dimensions, and a one-pair walk where both flags rise together. Directed runs cover refused starts, and writes plus start pulses injected mid-walk whose lack of effect shows in the address stream and in a following walk.

// File: rtl/scan_agen_pkg.sv
package scan_agen_pkg;

  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_ROW_FIRST = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ROW_INC   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ROW_CEIL  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_NEST      = 3'd6;

  // parameters per dimension: first, increment, ceiling
  localparam int SEL_PER_DIM = 3;
  localparam int DIM_ROW     = 0;
  localparam int DIM_COL     = 1;
  localparam int NUM_DIMS    = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_t;

endpackage

// File: rtl/scan_agen_cfg.sv
module scan_agen_cfg
  import scan_agen_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [SEL_W-1:0]                cfg_sel,
  input  logic [IDX_W-1:0]                cfg_wdata,
  input  logic                            busy,
  output logic [NUM_DIMS-1:0][IDX_W-1:0]  first_o,
  output logic [NUM_DIMS-1:0][IDX_W-1:0]  inc_o,
  output logic [NUM_DIMS-1:0][IDX_W-1:0]  ceil_o,
  output logic                            col_inner_o
);

  logic wr_ok;
  assign wr_ok = cfg_we && !busy;

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
    localparam logic [SEL_W-1:0] BASE = SEL_W'(d * SEL_PER_DIM);

    always_ff @(posedge clk) begin
      if (rst) begin
        first_o[d] <= '0;
        inc_o[d]   <= IDX_W'(1);
        ceil_o[d]  <= '0;
      end else if (wr_ok) begin
        if (cfg_sel == BASE + SEL_ROW_FIRST) first_o[d] <= cfg_wdata;
        if (cfg_sel == BASE + SEL_ROW_INC)   inc_o[d]   <= cfg_wdata;
        if (cfg_sel == BASE + SEL_ROW_CEIL)  ceil_o[d]  <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_inner_o <= 1'b1;
    end else if (wr_ok && cfg_sel == SEL_NEST) begin
      col_inner_o <= (cfg_wdata != '0);
    end
  end

  // R10: parameters frozen while a walk runs
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_we) |=> ($stable(first_o) && $stable(inc_o) && $stable(ceil_o)
                          && $stable(col_inner_o)));

endmodule

// File: rtl/scan_agen_axis.sv
module scan_agen_axis #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] cur,
  input  logic [IDX_W-1:0] inc,
  input  logic [IDX_W-1:0] ceil,
  input  logic [IDX_W-1:0] first,
  output logic [IDX_W-1:0] stepped,
  output logic             at_end,
  output logic             bad
);

  localparam int EXT_W = IDX_W + 1;

  logic [EXT_W-1:0] sum_ext;

  // one spare bit keeps a sum above the index range visible to the compare
  assign sum_ext = {1'b0, cur} + {1'b0, inc};
  assign at_end  = sum_ext > {1'b0, ceil};
  assign stepped = sum_ext[IDX_W-1:0];
  assign bad     = (inc == '0) || (first > ceil);

endmodule

// File: rtl/scan_agen_ctrl.sv
module scan_agen_ctrl
  import scan_agen_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [NUM_DIMS-1:0][IDX_W-1:0]  first_i,
  input  logic [NUM_DIMS-1:0][IDX_W-1:0]  inc_i,
  input  logic [NUM_DIMS-1:0][IDX_W-1:0]  ceil_i,
  input  logic                            col_inner_i,
  input  logic                            out_ready,
  output logic                            out_valid,
  output logic [IDX_W-1:0]                out_row,
  output logic [IDX_W-1:0]                out_col,
  output logic                            out_last_inner,
  output logic                            out_last_scan,
  output logic                            scan_done,
  output logic                            busy,
  output logic                            cfg_err
);

  walk_state_t                     state_q;
  logic [NUM_DIMS-1:0][IDX_W-1:0]  idx_q;
  logic [NUM_DIMS-1:0][IDX_W-1:0]  stepped;
  logic [NUM_DIMS-1:0]             at_end;
  logic [NUM_DIMS-1:0]             dim_bad;
  logic                            valid_q, done_q, err_q;

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_axis
    scan_agen_axis #(.IDX_W(IDX_W)) axis_i (
      .cur     (idx_q[d]),
      .inc     (inc_i[d]),
      .ceil    (ceil_i[d]),
      .first   (first_i[d]),
      .stepped (stepped[d]),
      .at_end  (at_end[d]),
      .bad     (dim_bad[d])
    );
  end

  logic in_d, out_d;
  logic inner_end, outer_end, fire;

  assign in_d      = col_inner_i;
  assign out_d     = !col_inner_i;
  assign inner_end = at_end[in_d];
  assign outer_end = at_end[out_d];
  assign fire      = valid_q && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (|dim_bad) begin
              err_q <= 1'b1;
            end else begin
              err_q   <= 1'b0;
              idx_q   <= first_i;
              valid_q <= 1'b1;
              state_q <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (fire) begin
            if (inner_end && outer_end) begin
              valid_q <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (inner_end) begin
              idx_q[in_d]  <= first_i[in_d];
              idx_q[out_d] <= stepped[out_d];
            end else begin
              idx_q[in_d]  <= stepped[in_d];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid      = valid_q;
  assign out_row        = idx_q[DIM_ROW];
  assign out_col        = idx_q[DIM_COL];
  assign out_last_inner = valid_q && inner_end;
  assign out_last_scan  = valid_q && inner_end && outer_end;
  assign scan_done      = done_q;
  assign busy           = (state_q == ST_WALK);
  assign cfg_err        = err_q;

  // R8: stalled pair holds
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_col)));

  // R5: emitted indices never exceed their ceilings
  assert_within_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_row <= ceil_i[DIM_ROW] && out_col <= ceil_i[DIM_COL]));

  // R7: done is a single-cycle pulse, issued only after the final accepted pair
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> ($past(out_valid && out_ready && out_last_scan) && !out_valid && !busy));

  // R9: refused start leaves the block idle with the error raised
  assert_refuse_bad_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (|dim_bad)) |=> (!busy && !out_valid && cfg_err));

  // R11: start while walking does not move the indices
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !out_ready) |=> $stable(idx_q));

endmodule

// File: rtl/scan_agen.sv
module scan_agen
  import scan_agen_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [IDX_W-1:0] cfg_wdata,
  input  logic             start,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_row,
  output logic [IDX_W-1:0] out_col,
  output logic             out_last_inner,
  output logic             out_last_scan,
  output logic             scan_done,
  output logic             busy,
  output logic             cfg_err
);

  logic [NUM_DIMS-1:0][IDX_W-1:0] first_w, inc_w, ceil_w;
  logic                           col_inner_w;

  scan_agen_cfg #(.IDX_W(IDX_W)) cfg_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .busy        (busy),
    .first_o     (first_w),
    .inc_o       (inc_w),
    .ceil_o      (ceil_w),
    .col_inner_o (col_inner_w)
  );

  scan_agen_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .first_i        (first_w),
    .inc_i          (inc_w),
    .ceil_i         (ceil_w),
    .col_inner_i    (col_inner_w),
    .out_ready      (out_ready),
    .out_valid      (out_valid),
    .out_row        (out_row),
    .out_col        (out_col),
    .out_last_inner (out_last_inner),
    .out_last_scan  (out_last_scan),
    .scan_done      (scan_done),
    .busy           (busy),
    .cfg_err        (cfg_err)
  );

endmodule

// File: tb/scan_agen_tb_top.sv
module scan_agen_tb_top;

  localparam int IDX_W = 16;
  localparam int NVEC  = 7;
  // fields: row first, row inc, row ceil, col first, col inc, col ceil, nest, beats
  localparam int VEC [0:NVEC-1][0:7] = '{
    '{0,     1, 2,     0,  1, 3,  1, 12},
    '{0,     1, 2,     0,  1, 3,  0, 12},
    '{1,     3, 8,     2,  2, 7,  1, 9},
    '{5,     1, 5,     0,  5, 9,  0, 2},
    '{65530, 4, 65535, 10, 7, 20, 1, 4},
    '{0,     1, 0,     0,  1, 0,  1, 1},
    '{3,     2, 6,     0,  3, 10, 0, 8}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_sel = '0;
  logic [IDX_W-1:0] cfg_wdata = '0;
  logic             start = 1'b0;
  logic             out_ready = 1'b0;
  logic             out_valid, out_last_inner, out_last_scan, scan_done, busy, cfg_err;
  logic [IDX_W-1:0] out_row, out_col;

  int checks = 0;
  int bad    = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  scan_agen #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start(start), .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_col(out_col), .out_last_inner(out_last_inner), .out_last_scan(out_last_scan),
    .scan_done(scan_done), .busy(busy), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    cfg_we    = 1'b1;
    cfg_sel   = 3'(sel);
    cfg_wdata = IDX_W'(data);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic program_set(input int rs, rinc, rc, cs, cinc, cc, nest);
    wr(0, rs); wr(1, rinc); wr(2, rc);
    wr(3, cs); wr(4, cinc); wr(5, cc); wr(6, nest);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Run one walk against a loop-nest model; poke injects a write and a start mid-walk
  task automatic run_walk(input int rs, rinc, rc, cs, cinc, cc, nest, nbeats,
                          input int seed, input bit poke);
    int er, ec, beats, cyc;
    bit fin, stall, poked, li, ls;
    logic [IDX_W-1:0] srow, scol;
    string ord;
    er = rs; ec = cs; beats = 0; cyc = 0; fin = 0; stall = 0; poked = 0;
    ord = (nest != 0) ? "R3" : "R4";
    pulse_start();
    while (!fin && cyc < 5000) begin
      cfg_we = 1'b0;
      start  = 1'b0;
      if (stall) begin
        chk("R8 valid held", out_valid, 1);
        chk("R8 row held", out_row, srow);
        chk("R8 col held", out_col, scol);
        stall = 0;
      end
      chk("R7 valid during walk", out_valid, 1);
      if (poke && beats == 3 && !poked) begin
        cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = IDX_W'(1);
        start  = 1'b1;
        poked  = 1;
      end
      out_ready = ((cyc + seed) % 3) != 0;
      if (out_valid && out_ready) begin
        if (nest != 0) begin
          li = (ec + cinc > cc);
          ls = li && (er + rinc > rc);
        end else begin
          li = (er + rinc > rc);
          ls = li && (ec + cinc > cc);
        end
        chk({ord, " R5 row"}, out_row, er);
        chk({ord, " R5 col"}, out_col, ec);
        chk("R6 last inner", out_last_inner, li);
        chk("R6 last scan", out_last_scan, ls);
        beats++;
        if (ls) fin = 1;
        else if (nest != 0) begin
          if (li) begin ec = cs; er = er + rinc; end else ec = ec + cinc;
        end else begin
          if (li) begin er = rs; ec = ec + cinc; end else er = er + rinc;
        end
      end else begin
        stall = 1; srow = out_row; scol = out_col;
      end
      cyc++;
      @(negedge clk);
    end
    cfg_we = 1'b0; start = 1'b0; out_ready = 1'b0;
    chk("R7 done after last", scan_done, 1);
    chk("R7 valid low at end", out_valid, 0);
    chk("R7 busy low at end", busy, 0);
    chk("R5 beat count", beats, nbeats);
    @(negedge clk);
    chk("R7 done one cycle", scan_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid", out_valid, 0);
    chk("R1 done", scan_done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", cfg_err, 0);
    chk("R1 last inner", out_last_inner, 0);
    chk("R1 last scan", out_last_scan, 0);

    // table walk (R2 programming for every set)
    for (int v = 0; v < NVEC; v++) begin
      program_set(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      run_walk(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
               VEC[v][6], VEC[v][7], v, 1'b0);
    end

    // R9: zero increment refused
    program_set(0, 0, 4, 0, 1, 4, 1);
    pulse_start();
    chk("R9 err on zero inc", cfg_err, 1);
    chk("R9 busy stays low", busy, 0);
    chk("R9 no pair", out_valid, 0);
    repeat (2) @(negedge clk);
    chk("R9 still no pair", out_valid, 0);

    // R9: first above ceiling refused
    program_set(0, 1, 4, 6, 1, 4, 1);
    pulse_start();
    chk("R9 err on first above ceiling", cfg_err, 1);
    chk("R9 busy low again", busy, 0);

    // R9 clear, R10 and R11 mid-walk pokes
    program_set(0, 1, 2, 0, 1, 3, 1);
    run_walk(0, 1, 2, 0, 1, 3, 1, 12, 2, 1'b1);
    chk("R9 err cleared by good start", cfg_err, 0);
    // R10: row ceiling write during walk was dropped; a fresh walk still gives 12 pairs
    run_walk(0, 1, 2, 0, 1, 3, 1, 12, 1, 1'b0);

    // R2: write while idle takes effect at next start (row ceiling 1 -> 8 pairs)
    wr(2, 1);
    run_walk(0, 1, 1, 0, 1, 3, 1, 8, 0, 1'b0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule